// File: doc/BRIEF.md
# Descriptor Ring Transfer Sequencer

This block is the control core of a DMA-style two-wire bus master. A circular ring of 16-byte transfer descriptors lives in a local memory that the host fills through a word-wide port. Software moves a head pointer forward and sets a start bit. The sequencer then consumes descriptors from its own tail pointer up to, but not including, the head. Each descriptor is handed in turn to a transaction engine over a start/done handshake.

When the engine reports back, the sequencer writes the result status and the byte counts into that descriptor in place. Only after that write does it move the tail forward. It also raises completion or error interrupt status, which software clears by writing ones.

Three small registers carry the control fields, the status fields and the ring size. The bit-level bus protocol, the host fabric and real memory fetches are left to neighbouring blocks.

Top module: `desc_ring_seq`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the size register reads ENTRIES-1 and `irq` is low.
- R2: Register word 0 (control) holds start in bit 0, error-interrupt enable in bit 4 and the software head in bits 23:16. Register word 1 (status) holds busy in bit 0, error-interrupt status in bit 4, completion-interrupt status in bit 5 and the hardware tail in bits 23:16. Register word 2 (size) holds the last ring index in bits 7:0. A size write above ENTRIES-1 is clamped to ENTRIES-1.
- R3: While start is 1 and tail differs from head, the descriptors are issued to the engine in ring order starting at the tail. `eng_hdr` carries descriptor word 0, with target+R/W in bits 7:0, write length or command in 15:8, read length in 23:16 and control flags in 31:24. `eng_dptr` carries word 3 in its upper half and word 2 in its lower half. A descriptor occupies memory words slot*4 to slot*4+3.
- R4: On completion, descriptor word 1 becomes {tx count[31:24], rx count[23:16], unchanged retry byte[15:8], engine status[7:0]}. Words 0, 2 and 3 are left unchanged.
- R5: The tail advances only after that descriptor's write-back. It steps by one and wraps to 0 after the last index held in the size register.
- R6: With start set and tail equal to head, no descriptor is issued and busy stays 0.
- R7: Completion-interrupt status is set when a descriptor whose control flag bit 6 is 1 finishes. It is not set by descriptors without that flag.
- R8: A descriptor with control flag bit 7 set whose status bit 0 (success) is 0 halts the ring. The tail stays on that entry, start is cleared, error-interrupt status is set and no later descriptor is issued. A failed descriptor without bit 7 does not halt the ring.
- R9: Writing 1 to status bit 4 or bit 5 clears that bit. Writing 0 leaves it unchanged.
- R10: `irq` is high when completion status is 1, or when error status and the error enable are both 1.
- R11: `eng_start` is a one-cycle pulse per descriptor. The sequencer waits any number of cycles for `eng_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | input | 1 | Descriptor memory write strobe |
| mem_addr | input | MAW | Descriptor memory word address |
| mem_wdata | input | 32 | Descriptor memory write data |
| mem_rdata | output | 32 | Descriptor memory read data (combinational) |
| eng_start | output | 1 | Start pulse to the transaction engine |
| eng_hdr | output | 32 | Descriptor header word for the engine |
| eng_dptr | output | 64 | Data pointer for the engine |
| eng_done | input | 1 | Engine completion strobe |
| eng_status | input | 8 | Result status flags |
| eng_rx_cnt | input | 8 | Bytes received |
| eng_tx_cnt | input | 8 | Bytes transmitted |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the wrap from the last index back to zero under a shrunken ring. A design that wrapped at the physical depth instead would fetch stale entries and leave the tail wrong. A stop-on-error descriptor sits between two good ones, so a design that kept going, advanced the tail past the failure or left start set is caught by the unchanged word of the next entry and by the tail readback. The bench also covers a failure without the halt flag, an empty ring with start set, a write of zero to the interrupt status, and an error masked by its enable. Each of these would show as a spurious halt, a phantom issue, a lost interrupt or a stuck `irq`.

// File: rtl/dring_pkg.sv
package dring_pkg;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_SIZE = 2'd2;

    localparam int BIT_START  = 0;
    localparam int BIT_ERR_EN = 4;
    localparam int BIT_BUSY   = 0;
    localparam int BIT_ERR_IS = 4;
    localparam int BIT_DONE_IS = 5;

    localparam int FLAG_IRQ  = 6;
    localparam int FLAG_HALT = 7;
    localparam int STS_OK    = 0;

    typedef struct packed {
        logic [7:0] flags;
        logic [7:0] rd_len;
        logic [7:0] wr_len;
        logic [7:0] target;
    } desc_hdr_t;

    typedef struct packed {
        logic [7:0] tx_cnt;
        logic [7:0] rx_cnt;
        logic [7:0] retry;
        logic [7:0] status;
    } desc_res_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_WB,
        SQ_ADV
    } sq_state_t;

    function automatic logic [7:0] ring_step(input logic [7:0] p, input logic [7:0] last);
        return (p >= last) ? 8'd0 : p + 8'd1;
    endfunction

endpackage

// File: rtl/dring_desc_ram.sv
module dring_desc_ram
    import dring_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IW = $clog2(ENTRIES),
    localparam int AW = IW + 2
) (
    input  logic            clk,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    input  logic [IW-1:0]   rd_idx,
    output desc_hdr_t       rd_hdr,
    output logic [7:0]      rd_retry,
    output logic [63:0]     rd_dptr,
    input  logic            wb_we,
    input  logic [IW-1:0]   wb_idx,
    input  desc_res_t       wb_word
);

    logic [31:0] mem [ENTRIES*4];

    always_ff @(posedge clk) begin
        if (wb_we) begin
            mem[{wb_idx, 2'd1}] <= wb_word;
        end else if (host_we) begin
            mem[host_addr] <= host_wdata;
        end
    end

    assign host_rdata = mem[host_addr];
    assign rd_hdr     = desc_hdr_t'(mem[{rd_idx, 2'd0}]);
    assign rd_retry   = mem[{rd_idx, 2'd1}][15:8];
    assign rd_dptr    = {mem[{rd_idx, 2'd3}], mem[{rd_idx, 2'd2}]};

endmodule

// File: rtl/dring_regs.sv
module dring_regs
    import dring_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam logic [7:0] LAST_MAX = 8'(ENTRIES - 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        busy_i,
    input  logic        tail_adv_i,
    input  logic        halt_i,
    input  logic        set_done_i,
    output logic        start_o,
    output logic [7:0]  head_o,
    output logic [7:0]  tail_o,
    output logic        irq_o
);

    logic       start_q, err_en_q, err_is_q, done_is_q;
    logic [7:0] head_q, tail_q, last_q;
    logic       wr_ctrl, wr_stat, wr_size;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_stat = reg_we && (reg_addr == RA_STAT);
    assign wr_size = reg_we && (reg_addr == RA_SIZE);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q   <= 1'b0;
            err_en_q  <= 1'b0;
            head_q    <= 8'd0;
            tail_q    <= 8'd0;
            last_q    <= LAST_MAX;
            err_is_q  <= 1'b0;
            done_is_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                start_q  <= reg_wdata[BIT_START];
                err_en_q <= reg_wdata[BIT_ERR_EN];
                head_q   <= reg_wdata[23:16];
            end else if (halt_i) begin
                start_q <= 1'b0;
            end
            if (wr_size) begin
                last_q <= (reg_wdata[7:0] > LAST_MAX) ? LAST_MAX : reg_wdata[7:0];
            end
            if (tail_adv_i) begin
                tail_q <= ring_step(tail_q, last_q);
            end
            if (halt_i) begin
                err_is_q <= 1'b1;
            end else if (wr_stat && reg_wdata[BIT_ERR_IS]) begin
                err_is_q <= 1'b0;
            end
            if (set_done_i) begin
                done_is_q <= 1'b1;
            end else if (wr_stat && reg_wdata[BIT_DONE_IS]) begin
                done_is_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = 32'd0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[BIT_START]  = start_q;
                reg_rdata[BIT_ERR_EN] = err_en_q;
                reg_rdata[23:16]      = head_q;
            end
            RA_STAT: begin
                reg_rdata[BIT_BUSY]    = busy_i;
                reg_rdata[BIT_ERR_IS]  = err_is_q;
                reg_rdata[BIT_DONE_IS] = done_is_q;
                reg_rdata[23:16]       = tail_q;
            end
            RA_SIZE: reg_rdata[7:0] = last_q;
            default: reg_rdata = 32'd0;
        endcase
    end

    assign start_o = start_q;
    assign head_o  = head_q;
    assign tail_o  = tail_q;
    assign irq_o   = done_is_q | (err_is_q & err_en_q);

    // R5: tail moves by a single step or wraps to zero
    assert_tail_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tail_q != $past(tail_q)) |-> (tail_q == 8'd0 || tail_q == $past(tail_q) + 8'd1));

    // R8: a halt drops start and flags the error
    assert_halt_effect_R8: assert property (@(posedge clk) disable iff (rst)
        (halt_i && !wr_ctrl) |=> (!start_q && err_is_q));

    // R9: write-one-to-clear on completion status
    assert_w1c_done_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && reg_wdata[BIT_DONE_IS] && !set_done_i) |=> !done_is_q);

endmodule

// File: rtl/dring_fsm.sv
module dring_fsm
    import dring_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [7:0]    head_i,
    input  logic [7:0]    tail_i,
    input  desc_hdr_t     fetch_hdr_i,
    input  logic [7:0]    fetch_retry_i,
    input  logic [63:0]   fetch_dptr_i,
    output logic          eng_start_o,
    output desc_hdr_t     eng_hdr_o,
    output logic [63:0]   eng_dptr_o,
    input  logic          eng_done_i,
    input  logic [7:0]    eng_status_i,
    input  logic [7:0]    eng_rx_i,
    input  logic [7:0]    eng_tx_i,
    output logic          wb_we_o,
    output logic [IW-1:0] wb_idx_o,
    output desc_res_t     wb_word_o,
    output logic          tail_adv_o,
    output logic          halt_o,
    output logic          set_done_o,
    output logic          busy_o
);

    sq_state_t  state_q;
    desc_hdr_t  hdr_q;
    logic [63:0] dptr_q;
    logic [7:0] retry_q;
    desc_res_t  res_q;
    logic       go, failed;

    assign go = start_i && (tail_i != head_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            hdr_q   <= '0;
            dptr_q  <= 64'd0;
            retry_q <= 8'd0;
            res_q   <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: if (go) begin
                    hdr_q   <= fetch_hdr_i;
                    dptr_q  <= fetch_dptr_i;
                    retry_q <= fetch_retry_i;
                    state_q <= SQ_ISSUE;
                end
                SQ_ISSUE: state_q <= SQ_WAIT;
                SQ_WAIT: if (eng_done_i) begin
                    res_q   <= '{tx_cnt: eng_tx_i, rx_cnt: eng_rx_i,
                                 retry: retry_q, status: eng_status_i};
                    state_q <= SQ_WB;
                end
                SQ_WB:   state_q <= SQ_ADV;
                SQ_ADV:  state_q <= SQ_IDLE;
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign failed      = hdr_q.flags[FLAG_HALT] && !res_q.status[STS_OK];
    assign eng_start_o = (state_q == SQ_ISSUE);
    assign eng_hdr_o   = hdr_q;
    assign eng_dptr_o  = dptr_q;
    assign wb_we_o     = (state_q == SQ_WB);
    assign wb_idx_o    = tail_i[IW-1:0];
    assign wb_word_o   = res_q;
    assign tail_adv_o  = (state_q == SQ_ADV) && !failed;
    assign halt_o      = (state_q == SQ_ADV) && failed;
    assign set_done_o  = (state_q == SQ_ADV) && hdr_q.flags[FLAG_IRQ];
    assign busy_o      = (state_q != SQ_IDLE);

    // R11: one start pulse per descriptor
    assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |=> !eng_start_o);

    // R5: the tail only moves right after a write-back
    assert_wb_before_adv_R5: assert property (@(posedge clk) disable iff (rst)
        tail_adv_o |-> $past(wb_we_o));

    // R6: an empty ring or cleared start keeps the sequencer idle
    assert_empty_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && !go) |=> (state_q == SQ_IDLE));

endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
    import dring_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IW  = $clog2(ENTRIES),
    localparam int MAW = IW + 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_we,
    input  logic [1:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic           mem_we,
    input  logic [MAW-1:0] mem_addr,
    input  logic [31:0]    mem_wdata,
    output logic [31:0]    mem_rdata,
    output logic           eng_start,
    output logic [31:0]    eng_hdr,
    output logic [63:0]    eng_dptr,
    input  logic           eng_done,
    input  logic [7:0]     eng_status,
    input  logic [7:0]     eng_rx_cnt,
    input  logic [7:0]     eng_tx_cnt,
    output logic           irq
);

    logic        start_w, busy_w, adv_w, halt_w, done_w, wb_we_w;
    logic [7:0]  head_w, tail_w, retry_w;
    logic [63:0] dptr_w;
    logic [IW-1:0] wb_idx_w;
    desc_hdr_t   fetch_hdr_w, eng_hdr_w;
    desc_res_t   wb_word_w;

    dring_desc_ram #(.ENTRIES(ENTRIES)) u_ram (
        .clk        (clk),
        .host_we    (mem_we),
        .host_addr  (mem_addr),
        .host_wdata (mem_wdata),
        .host_rdata (mem_rdata),
        .rd_idx     (tail_w[IW-1:0]),
        .rd_hdr     (fetch_hdr_w),
        .rd_retry   (retry_w),
        .rd_dptr    (dptr_w),
        .wb_we      (wb_we_w),
        .wb_idx     (wb_idx_w),
        .wb_word    (wb_word_w)
    );

    dring_regs #(.ENTRIES(ENTRIES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy_w),
        .tail_adv_i (adv_w),
        .halt_i     (halt_w),
        .set_done_i (done_w),
        .start_o    (start_w),
        .head_o     (head_w),
        .tail_o     (tail_w),
        .irq_o      (irq)
    );

    dring_fsm #(.ENTRIES(ENTRIES)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_w),
        .head_i        (head_w),
        .tail_i        (tail_w),
        .fetch_hdr_i   (fetch_hdr_w),
        .fetch_retry_i (retry_w),
        .fetch_dptr_i  (dptr_w),
        .eng_start_o   (eng_start),
        .eng_hdr_o     (eng_hdr_w),
        .eng_dptr_o    (eng_dptr),
        .eng_done_i    (eng_done),
        .eng_status_i  (eng_status),
        .eng_rx_i      (eng_rx_cnt),
        .eng_tx_i      (eng_tx_cnt),
        .wb_we_o       (wb_we_w),
        .wb_idx_o      (wb_idx_w),
        .wb_word_o     (wb_word_w),
        .tail_adv_o    (adv_w),
        .halt_o        (halt_w),
        .set_done_o    (done_w),
        .busy_o        (busy_w)
    );

    assign eng_hdr = eng_hdr_w;

endmodule

// File: tb/desc_ring_seq_test.sv
module desc_ring_seq_test;

    localparam int ENT = 32;
    localparam int MAW = $clog2(ENT) + 2;
    localparam int QN  = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic mem_we = 1'b0;
    logic [MAW-1:0] mem_addr = '0;
    logic [31:0] mem_wdata = 32'd0;
    logic [31:0] mem_rdata;
    logic eng_start;
    logic [31:0] eng_hdr;
    logic [63:0] eng_dptr;
    logic eng_done = 1'b0;
    logic [7:0] eng_status = 8'd0, eng_rx_cnt = 8'd0, eng_tx_cnt = 8'd0;
    logic irq;

    always #4 clk = ~clk;

    desc_ring_seq #(.ENTRIES(ENT)) uut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .eng_start(eng_start), .eng_hdr(eng_hdr), .eng_dptr(eng_dptr),
        .eng_done(eng_done), .eng_status(eng_status),
        .eng_rx_cnt(eng_rx_cnt), .eng_tx_cnt(eng_tx_cnt), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] sh [ENT*4];
    logic [7:0]  rsp_st [QN];
    logic [7:0]  rsp_rx [QN];
    logic [7:0]  rsp_tx [QN];
    int          rsp_slot [QN];
    logic [31:0] iss_hdr [QN];
    logic [63:0] iss_dptr [QN];
    int nq = 0;
    int eng_cnt = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic mem_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        mem_we = 1'b1; mem_addr = MAW'(a); mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic mem_rd(input int a, output logic [31:0] d);
        mem_addr = MAW'(a);
        #1;
        d = mem_rdata;
    endtask

    function automatic logic [31:0] exp_word1(input int k);
        return {rsp_tx[k], rsp_rx[k], sh[rsp_slot[k]*4+1][15:8], rsp_st[k]};
    endfunction

    task automatic prep(input int slot, input logic [7:0] flags, input logic [7:0] st, input bit queued);
        sh[slot*4]   = {flags, 24'($urandom)};
        sh[slot*4+1] = $urandom;
        sh[slot*4+2] = $urandom;
        sh[slot*4+3] = $urandom;
        for (int k = 0; k < 4; k++) mem_wr(slot*4 + k, sh[slot*4 + k]);
        if (queued) begin
            rsp_slot[nq] = slot;
            rsp_st[nq]   = st;
            rsp_rx[nq]   = 8'($urandom);
            rsp_tx[nq]   = 8'($urandom);
            nq++;
        end
    endtask

    task automatic wait_idle();
        logic [31:0] c, s;
        bit ok;
        ok = 1'b0;
        for (int t = 0; t < 3000; t++) begin
            @(negedge clk);
            reg_rd(2'd0, c);
            reg_rd(2'd1, s);
            if (!s[0] && (!c[0] || s[23:16] == c[23:16])) begin
                ok = 1'b1;
                break;
            end
        end
        chk(ok, "R3 batch completes", {63'd0, ok}, 64'd1);
    endtask

    task automatic verify(input int from);
        logic [31:0] d;
        chk(eng_cnt == nq, "R3 issue count", 64'(eng_cnt), 64'(nq));
        for (int k = from; k < nq; k++) begin
            int slot;
            slot = rsp_slot[k];
            chk(iss_hdr[k] == sh[slot*4], "R3 header to engine", 64'(iss_hdr[k]), 64'(sh[slot*4]));
            chk(iss_dptr[k] == {sh[slot*4+3], sh[slot*4+2]}, "R3 pointer to engine",
                iss_dptr[k], {sh[slot*4+3], sh[slot*4+2]});
            mem_rd(slot*4+1, d);
            chk(d == exp_word1(k), "R4 result write-back", 64'(d), 64'(exp_word1(k)));
            mem_rd(slot*4, d);
            chk(d == sh[slot*4], "R4 header untouched", 64'(d), 64'(sh[slot*4]));
            mem_rd(slot*4+3, d);
            chk(d == sh[slot*4+3], "R4 pointer untouched", 64'(d), 64'(sh[slot*4+3]));
            sh[slot*4+1] = exp_word1(k);
        end
    endtask

    // transaction engine model
    initial begin
        forever begin
            @(negedge clk);
            if (eng_start) begin
                int k;
                k = eng_cnt % QN;
                iss_hdr[k]  = eng_hdr;
                iss_dptr[k] = eng_dptr;
                @(negedge clk);
                chk(eng_start == 1'b0, "R11 start is a single pulse", {63'd0, eng_start}, 64'd0);
                repeat ($urandom_range(0, 3)) @(negedge clk);
                eng_status = rsp_st[k];
                eng_rx_cnt = rsp_rx[k];
                eng_tx_cnt = rsp_tx[k];
                eng_done   = 1'b1;
                @(negedge clk);
                eng_done   = 1'b0;
                eng_cnt++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] c, s, z, d;
        int base, ptail, hd, n, cnt0;
        bit want_mis;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        reg_rd(2'd0, c); chk(c == 32'd0, "R1 control reset", 64'(c), 64'd0);
        reg_rd(2'd1, s); chk(s == 32'd0, "R1 status reset", 64'(s), 64'd0);
        reg_rd(2'd2, z); chk(z == 32'(ENT-1), "R1 size reset", 64'(z), 64'(ENT-1));
        chk(irq == 1'b0, "R1 irq low", {63'd0, irq}, 64'd0);

        // R2 register layout and size clamp
        reg_wr(2'd0, 32'h0005_0010);
        reg_rd(2'd0, c); chk(c == 32'h0005_0010, "R2 control readback", 64'(c), 64'h50010);
        reg_wr(2'd2, 32'd7);
        reg_rd(2'd2, z); chk(z == 32'd7, "R2 size readback", 64'(z), 64'd7);
        reg_wr(2'd2, 32'h0000_00FF);
        reg_rd(2'd2, z); chk(z == 32'(ENT-1), "R2 size clamp", 64'(z), 64'(ENT-1));
        reg_rd(2'd1, s); chk(s == 32'd0, "R6 no run without start", 64'(s), 64'd0);
        chk(eng_cnt == 0, "R6 no issue without start", 64'(eng_cnt), 64'd0);
        reg_wr(2'd0, 32'd0);

        // A: straight batch, last entry requests completion interrupt (R3 R4 R7 R10)
        base = nq;
        for (int i = 0; i < 4; i++)
            prep(i, (8'($urandom) & 8'h3F) | ((i == 3) ? 8'h40 : 8'h00), 8'($urandom) | 8'h01, 1'b1);
        reg_wr(2'd0, 32'h0004_0001);
        wait_idle();
        verify(base);
        reg_rd(2'd1, s);
        chk(s[23:16] == 8'd4, "R5 tail after batch", 64'(s[23:16]), 64'd4);
        chk(s[5] == 1'b1, "R7 completion status set", 64'(s[5]), 64'd1);
        chk(s[4] == 1'b0, "R8 no error status", 64'(s[4]), 64'd0);
        chk(irq == 1'b1, "R10 irq from completion", {63'd0, irq}, 64'd1);

        // R9 write-one-to-clear
        reg_wr(2'd1, 32'd0);
        reg_rd(2'd1, s); chk(s[5] == 1'b1, "R9 zero write keeps status", 64'(s[5]), 64'd1);
        reg_wr(2'd1, 32'h20);
        reg_rd(2'd1, s); chk(s[5] == 1'b0, "R9 one write clears status", 64'(s[5]), 64'd0);
        chk(irq == 1'b0, "R10 irq drops", {63'd0, irq}, 64'd0);

        // B: wrap on a six-entry ring, failure without halt flag (R5 R8 R7)
        reg_wr(2'd2, 32'd5);
        base = nq;
        prep(4, 8'($urandom) & 8'h3F, 8'h01, 1'b1);
        prep(5, 8'($urandom) & 8'h3F, 8'h08, 1'b1);
        prep(0, 8'($urandom) & 8'h3F, 8'h01, 1'b1);
        prep(1, 8'($urandom) & 8'h3F, 8'h01, 1'b1);
        reg_wr(2'd0, 32'h0002_0001);
        wait_idle();
        verify(base);
        reg_rd(2'd1, s);
        chk(s[23:16] == 8'd2, "R5 tail wraps at ring size", 64'(s[23:16]), 64'd2);
        chk(s[5] == 1'b0, "R7 no completion without flag", 64'(s[5]), 64'd0);
        reg_rd(2'd0, c);
        chk(c[0] == 1'b1, "R8 failure without halt flag keeps start", 64'(c[0]), 64'd1);
        reg_wr(2'd2, 32'(ENT-1));

        // C: stop on error (R8 R10 R9)
        base = nq;
        prep(2, 8'($urandom) & 8'h3F, 8'h01, 1'b1);
        prep(3, (8'($urandom) & 8'h3F) | 8'h80, 8'h08, 1'b1);
        prep(4, 8'($urandom) & 8'h3F, 8'h01, 1'b0);
        reg_wr(2'd0, 32'h0005_0011);
        wait_idle();
        verify(base);
        reg_rd(2'd1, s);
        chk(s[23:16] == 8'd3, "R8 tail holds failed entry", 64'(s[23:16]), 64'd3);
        chk(s[4] == 1'b1, "R8 error status set", 64'(s[4]), 64'd1);
        reg_rd(2'd0, c);
        chk(c[0] == 1'b0, "R8 start cleared", 64'(c[0]), 64'd0);
        mem_rd(4*4+1, d);
        chk(d == sh[4*4+1], "R8 later entry untouched", 64'(d), 64'(sh[4*4+1]));
        chk(irq == 1'b1, "R10 irq from enabled error", {63'd0, irq}, 64'd1);
        reg_wr(2'd0, 32'h0005_0000);
        chk(irq == 1'b0, "R10 error masked by enable", {63'd0, irq}, 64'd0);
        reg_rd(2'd1, s); chk(s[4] == 1'b1, "R9 error status held", 64'(s[4]), 64'd1);
        reg_wr(2'd1, 32'h10);
        reg_rd(2'd1, s); chk(s[4] == 1'b0, "R9 error status cleared", 64'(s[4]), 64'd0);

        // resume from the failed entry
        base = nq;
        prep(3, 8'($urandom) & 8'h3F, 8'h01, 1'b1);
        prep(4, 8'($urandom) & 8'h3F, 8'h01, 1'b1);
        reg_wr(2'd0, 32'h0005_0001);
        wait_idle();
        verify(base);
        reg_rd(2'd1, s);
        chk(s[23:16] == 8'd5, "R5 tail after resume", 64'(s[23:16]), 64'd5);

        // D: empty ring with start set (R6)
        cnt0 = eng_cnt;
        reg_wr(2'd0, 32'h0005_0001);
        repeat (10) @(negedge clk);
        reg_rd(2'd1, s);
        chk(s[0] == 1'b0, "R6 idle on empty ring", 64'(s[0]), 64'd0);
        chk(eng_cnt == cnt0, "R6 no issue on empty ring", 64'(eng_cnt), 64'(cnt0));

        // E: random batches on the full ring
        ptail = 5;
        for (int r = 0; r < 12; r++) begin
            base = nq;
            n = $urandom_range(1, 12);
            want_mis = 1'b0;
            reg_wr(2'd1, 32'h30);
            for (int i = 0; i < n; i++) begin
                logic [7:0] fl;
                fl = 8'($urandom) & 8'h7F;
                if (fl[6]) want_mis = 1'b1;
                prep((ptail + i) % ENT, fl, 8'($urandom), 1'b1);
            end
            hd = (ptail + n) % ENT;
            reg_wr(2'd0, {8'd0, 8'(hd), 16'h0001});
            wait_idle();
            verify(base);
            reg_rd(2'd1, s);
            chk(s[23:16] == 8'(hd), "R5 tail after random batch", 64'(s[23:16]), 64'(hd));
            chk(s[5] == want_mis, "R7 completion status random", 64'(s[5]), {63'd0, want_mis});
            ptail = hd;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule